// File: doc/BRIEF.md
# Protected System Control Register File

This block is a 32-bit control register bank on an APB-style slave port. Every access is one full aligned word. The word index is the byte address shifted right by two. A magic-key register at word 0 guards all the other registers. Until software writes the key, every write above word 0 is turned away with an error response, and reads still work.

The bank has several kinds of register. Some register pairs use two addresses: the lower address ORs written ones into the stored value, and the address one word above clears the written ones. Two strap words behave the same way, but a nonzero protect word two words above each strap freezes it against set writes. The clear alias still works while the strap is frozen. Two revision words are read-only. Three PLL extension words always read back with their lock bit set. A random-data word returns a new value from an internal LFSR on every read.

Reset loads fixed defaults. The revision words, the strap words and the key state are loaded from input ports. The control words are also driven out as vectors for the rest of the chip.

Top module: `syscfg_regfile`

## Requirements
- R1: An access takes place when psel and penable are both high. An address with paddr[1:0] not equal to 0 gives pslverr=1, reads as 0 and changes nothing.
- R2: A write to byte offset 0x000 stores 1 if pwdata equals 0x1688A8A8 and stores 0 for any other value. A read of 0x000 returns that 1 or 0, and unlocked_o shows the same bit.
- R3: While the key bit is 0, a write to any offset other than 0x000 gives pslverr=1 and leaves every register unchanged. Reads are still served.
- R4: The words at 0x040, 0x050, 0x080 and 0x090 are set registers: an accepted write ORs pwdata into the stored value.
- R5: The words at 0x044, 0x054, 0x084 and 0x094 clear the ones of pwdata in the word one address below. These alias words always read 0.
- R6: The strap words at 0x500 and 0x510 OR in written ones, unless the protect word at 0x508 or 0x518 (two words above) is nonzero. In that case the write is dropped without an error. The aliases at 0x504 and 0x514 clear strap bits even while the strap is protected.
- R7: A read of 0x204, 0x224 or 0x244 returns the stored word with bit 31 forced to 1.
- R8: A read of 0x540 returns the current LFSR state and then advances it one step: shift right, and XOR 0x80200003 if the bit shifted out was 1. The state after reset is 0xACE12024. A write there gives pslverr=1.
- R9: The words at 0x004 and 0x014 read as rev_i. A write to them gives pslverr=1 and changes nothing.
- R10: An offset at or beyond NUM_REGS words (0x580 by default) reads 0, gives pslverr=1 and ignores writes.
- R11: Reset values are 0xF7CFFFDC at 0x040, 0xFFFFFFFC at 0x050, 0xEFF43E8B at 0x080, 0xFFF0FFF0 at 0x090, 0x00000040 at 0x100 and 0x1000405F at 0x200. Straps come from strap0_i and strap1_i, the key bit from key_init_i, and every other word is 0.
- R12: Any other in-range word is a plain read/write register while the bank is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 16 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pslverr | output | 1 | Error response for a rejected access |
| rev_i | input | 32 | Revision value for both revision words |
| strap0_i | input | 32 | Reset value of strap word 0 |
| strap1_i | input | 32 | Reset value of strap word 1 |
| key_init_i | input | 1 | Reset value of the key bit |
| unlocked_o | output | 1 | Current key bit |
| rst_ctrl0_o | output | 32 | Reset control word 0 |
| rst_ctrl1_o | output | 32 | Reset control word 1 |
| clk_stop0_o | output | 32 | Clock stop word 0 |
| clk_stop1_o | output | 32 | Clock stop word 1 |
| strap0_o | output | 32 | Strap word 0 |
| strap1_o | output | 32 | Strap word 1 |

## Verification
On every cycle the assertions check these rules: the key compare result, the error response and the held outputs for locked writes, OR and AND-NOT updates of reset control word 0, the frozen strap under protect, the forced lock bit on PLL reads, the zero read data on out-of-range access, and a nonzero LFSR that moves on every read. The exact reset defaults, the random sequence, revision read-back, the clear aliases reading 0 and a working clear while the strap is protected can only be shown by the bench's directed scenarios, which compare them against values the bench works out itself.

// File: rtl/syscfg_pkg.sv
package syscfg_pkg;

  localparam logic [31:0] UNLOCK_WORD = 32'h1688_A8A8;
  localparam logic [31:0] LFSR_TAPS   = 32'h8020_0003;

  // Word indices whose position the behaviour depends on
  localparam int W_KEY    = 0;
  localparam int W_REVA   = 1;
  localparam int W_REVB   = 5;
  localparam int W_RST0   = 16;
  localparam int W_RST1   = 20;
  localparam int W_CLK0   = 32;
  localparam int W_CLK1   = 36;
  localparam int W_DRAM   = 64;
  localparam int W_PLLP   = 128;
  localparam int W_PLLX0  = 129;
  localparam int W_PLLX1  = 137;
  localparam int W_PLLX2  = 145;
  localparam int W_STRAP0 = 320;
  localparam int W_STRAP1 = 324;
  localparam int W_RAND   = 336;

  typedef enum logic [2:0] {
    K_PLAIN, K_KEY, K_RO, K_SET, K_CLR, K_STRAP, K_PLLX, K_RAND
  } reg_kind_e;

  function automatic reg_kind_e kind_of(input int w);
    case (w)
      W_KEY:                              return K_KEY;
      W_REVA, W_REVB:                     return K_RO;
      W_RST0, W_RST1, W_CLK0, W_CLK1:     return K_SET;
      W_RST0 + 1, W_RST1 + 1, W_CLK0 + 1,
      W_CLK1 + 1, W_STRAP0 + 1,
      W_STRAP1 + 1:                       return K_CLR;
      W_STRAP0, W_STRAP1:                 return K_STRAP;
      W_PLLX0, W_PLLX1, W_PLLX2:          return K_PLLX;
      W_RAND:                             return K_RAND;
      default:                            return K_PLAIN;
    endcase
  endfunction

  function automatic logic [31:0] default_word(input int w);
    case (w)
      W_RST0:  return 32'hF7CF_FFDC;
      W_RST1:  return 32'hFFFF_FFFC;
      W_CLK0:  return 32'hEFF4_3E8B;
      W_CLK1:  return 32'hFFF0_FFF0;
      W_DRAM:  return 32'h0000_0040;
      W_PLLP:  return 32'h1000_405F;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? LFSR_TAPS : 32'h0);
  endfunction

endpackage

// File: rtl/syscfg_decode.sv
module syscfg_decode
  import syscfg_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 352,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              unlocked,
  output logic              access_o,
  output logic              addr_ok_o,
  output logic [IDX_W-1:0]  widx_o,
  output reg_kind_e         kind_o,
  output logic              wr_ok_o,
  output logic              err_o
);

  logic [ADDR_W-3:0] word;
  logic              aligned, in_range, ro_target, lock_block;

  assign word      = paddr[ADDR_W-1:2];
  assign aligned   = (paddr[1:0] == 2'b00);
  assign in_range  = (int'(word) < NUM_REGS);
  assign access_o  = psel && penable;
  assign addr_ok_o = aligned && in_range;
  assign widx_o    = word[IDX_W-1:0];
  assign kind_o    = addr_ok_o ? kind_of(int'(word)) : K_PLAIN;

  assign ro_target  = (kind_o == K_RO) || (kind_o == K_RAND);
  assign lock_block = !unlocked && (kind_o != K_KEY);

  assign wr_ok_o = access_o && pwrite && addr_ok_o && !lock_block && !ro_target;
  assign err_o   = access_o && (!addr_ok_o || (pwrite && (lock_block || ro_target)));

endmodule

// File: rtl/syscfg_lfsr.sv
module syscfg_lfsr
  import syscfg_pkg::*;
#(
  parameter logic [31:0] SEED = 32'hACE1_2024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step_i,
  output logic [31:0] value_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value_o <= SEED;
    else if (step_i) value_o <= lfsr_next(value_o);
  end

  // R8
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    value_o != 32'h0);

  // R8
  lfsr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> value_o != $past(value_o));

endmodule

// File: rtl/syscfg_regfile.sv
module syscfg_regfile
  import syscfg_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          NUM_REGS = 352,
  parameter logic [31:0] RNG_SEED = 32'hACE1_2024,
  localparam int         IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pslverr,
  input  logic [31:0]       rev_i,
  input  logic [31:0]       strap0_i,
  input  logic [31:0]       strap1_i,
  input  logic              key_init_i,
  output logic              unlocked_o,
  output logic [31:0]       rst_ctrl0_o,
  output logic [31:0]       rst_ctrl1_o,
  output logic [31:0]       clk_stop0_o,
  output logic [31:0]       clk_stop1_o,
  output logic [31:0]       strap0_o,
  output logic [31:0]       strap1_o
);

  logic [31:0]      regs_q [NUM_REGS];
  logic             access, addr_ok, wr_ok;
  logic [IDX_W-1:0] widx, prot_idx, below_idx;
  reg_kind_e        kind;
  logic [31:0]      rand_word, rd_word;

  // Named events for the checks
  logic rd_ev, rand_rd_ev, strap_block_ev, locked_wr_ev;

  syscfg_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .unlocked(unlocked_o), .access_o(access), .addr_ok_o(addr_ok),
    .widx_o(widx), .kind_o(kind), .wr_ok_o(wr_ok), .err_o(pslverr)
  );

  assign rd_ev          = access && !pwrite && addr_ok;
  assign rand_rd_ev     = rd_ev && (kind == K_RAND);
  assign prot_idx       = widx + IDX_W'(2);
  assign below_idx      = widx - IDX_W'(1);
  assign strap_block_ev = wr_ok && (kind == K_STRAP) && (regs_q[prot_idx] != 32'h0);
  assign locked_wr_ev   = access && pwrite && addr_ok && !unlocked_o && (kind != K_KEY);

  syscfg_lfsr #(.SEED(RNG_SEED)) u_rng (
    .clk(clk), .rst_n(rst_n), .step_i(rand_rd_ev), .value_o(rand_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= default_word(i);
      regs_q[W_KEY]    <= {31'h0, key_init_i};
      regs_q[W_REVA]   <= rev_i;
      regs_q[W_REVB]   <= rev_i;
      regs_q[W_STRAP0] <= strap0_i;
      regs_q[W_STRAP1] <= strap1_i;
    end else if (wr_ok) begin
      case (kind)
        K_KEY:   regs_q[widx] <= {31'h0, pwdata == UNLOCK_WORD};
        K_SET:   regs_q[widx] <= regs_q[widx] | pwdata;
        K_CLR:   regs_q[below_idx] <= regs_q[below_idx] & ~pwdata;
        K_STRAP: if (!strap_block_ev) regs_q[widx] <= regs_q[widx] | pwdata;
        default: regs_q[widx] <= pwdata;
      endcase
    end
  end

  always_comb begin
    case (kind)
      K_PLLX:  rd_word = regs_q[widx] | 32'h8000_0000;
      K_RAND:  rd_word = rand_word;
      default: rd_word = regs_q[widx];
    endcase
    prdata = rd_ev ? rd_word : 32'h0;
  end

  assign unlocked_o  = regs_q[W_KEY][0];
  assign rst_ctrl0_o = regs_q[W_RST0];
  assign rst_ctrl1_o = regs_q[W_RST1];
  assign clk_stop0_o = regs_q[W_CLK0];
  assign clk_stop1_o = regs_q[W_CLK1];
  assign strap0_o    = regs_q[W_STRAP0];
  assign strap1_o    = regs_q[W_STRAP1];

  // R2
  key_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && kind == K_KEY) |=> unlocked_o == ($past(pwdata) == UNLOCK_WORD));

  // R3
  locked_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_wr_ev |-> pslverr);

  // R3
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_wr_ev |=> $stable(rst_ctrl0_o) && $stable(clk_stop1_o) && $stable(strap0_o));

  // R4
  set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access && pwrite && !pslverr && int'(widx) == W_RST0 && addr_ok)
    |=> rst_ctrl0_o == ($past(rst_ctrl0_o) | $past(pwdata)));

  // R5
  clr_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access && pwrite && !pslverr && int'(widx) == W_RST0 + 1 && addr_ok)
    |=> rst_ctrl0_o == ($past(rst_ctrl0_o) & ~$past(pwdata)));

  // R6
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_block_ev && int'(widx) == W_STRAP0) |=> $stable(strap0_o));

  // R7
  pll_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && kind == K_PLLX) |-> prdata[31]);

  // R10
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !addr_ok) |-> (prdata == 32'h0 && pslverr));

endmodule

// File: tb/syscfg_regfile_test.sv
module syscfg_regfile_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [15:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pslverr;
  logic [31:0] rev_i = 32'h0503_0303;
  logic [31:0] strap0_i = 32'h0000_00C0;
  logic [31:0] strap1_i = 32'h0000_0001;
  logic        key_init_i = 1'b0;
  logic        unlocked_o;
  logic [31:0] rst_ctrl0_o, rst_ctrl1_o, clk_stop0_o, clk_stop1_o, strap0_o, strap1_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] rng_model = 32'hACE1_2024;

  always #10 clk = ~clk;

  syscfg_regfile uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr),
    .rev_i(rev_i), .strap0_i(strap0_i), .strap1_i(strap1_i), .key_init_i(key_init_i),
    .unlocked_o(unlocked_o), .rst_ctrl0_o(rst_ctrl0_o), .rst_ctrl1_o(rst_ctrl1_o),
    .clk_stop0_o(clk_stop0_o), .clk_stop1_o(clk_stop1_o),
    .strap0_o(strap0_o), .strap1_o(strap1_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [15:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic err);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #2;
    rd = prdata; err = pslverr;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr_chk(input string req, input logic [15:0] a, input logic [31:0] d,
                        input logic exp_err);
    logic [31:0] rd; logic err;
    bus(1'b1, a, d, rd, err);
    check(req, {31'h0, err}, {31'h0, exp_err});
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp,
                        input logic exp_err);
    logic [31:0] rd; logic err;
    bus(1'b0, a, 32'h0, rd, err);
    check(req, rd, exp);
    check(req, {31'h0, err}, {31'h0, exp_err});
  endtask

  function automatic logic [31:0] rng_step(input logic [31:0] s);
    logic [31:0] n;
    n = {1'b0, s[31:1]};
    if (s[0]) begin
      n[31] = ~n[31]; n[21] = ~n[21]; n[1] = ~n[1]; n[0] = ~n[0];
    end
    return n;
  endfunction

  task automatic t_reset;
    check("R11 rst0", rst_ctrl0_o, 32'hF7CF_FFDC);
    check("R11 rst1", rst_ctrl1_o, 32'hFFFF_FFFC);
    check("R11 clk0", clk_stop0_o, 32'hEFF4_3E8B);
    check("R11 clk1", clk_stop1_o, 32'hFFF0_FFF0);
    check("R11 strap0", strap0_o, 32'h0000_00C0);
    check("R11 strap1", strap1_o, 32'h0000_0001);
    check("R11 key", {31'h0, unlocked_o}, 32'h0);
    rd_chk("R11 dram word", 16'h0100, 32'h0000_0040, 1'b0);
    rd_chk("R11 pll param", 16'h0200, 32'h1000_405F, 1'b0);
    rd_chk("R11 plain zero", 16'h0300, 32'h0, 1'b0);
  endtask

  task automatic t_locked;
    wr_chk("R3 locked set", 16'h0040, 32'h0000_0023, 1'b1);
    check("R3 rst0 held", rst_ctrl0_o, 32'hF7CF_FFDC);
    wr_chk("R3 locked plain", 16'h0300, 32'h1111_1111, 1'b1);
    rd_chk("R3 plain held", 16'h0300, 32'h0, 1'b0);
  endtask

  task automatic t_key;
    wr_chk("R2 wrong key", 16'h0000, 32'h1688_A8A9, 1'b0);
    rd_chk("R2 wrong reads 0", 16'h0000, 32'h0, 1'b0);
    wr_chk("R2 right key", 16'h0000, 32'h1688_A8A8, 1'b0);
    rd_chk("R2 key reads 1", 16'h0000, 32'h1, 1'b0);
    check("R2 unlocked_o", {31'h0, unlocked_o}, 32'h1);
  endtask

  task automatic t_setclr;
    wr_chk("R4 set rst0", 16'h0040, 32'h0000_0023, 1'b0);
    check("R4 rst0 or", rst_ctrl0_o, 32'hF7CF_FFFF);
    wr_chk("R5 clr rst0", 16'h0044, 32'hF000_0001, 1'b0);
    check("R5 rst0 and-not", rst_ctrl0_o, 32'h07CF_FFFE);
    rd_chk("R5 alias reads 0", 16'h0044, 32'h0, 1'b0);
    wr_chk("R4 set clk1", 16'h0090, 32'h0000_000F, 1'b0);
    check("R4 clk1 or", clk_stop1_o, 32'hFFF0_FFFF);
    wr_chk("R5 clr clk1", 16'h0094, 32'hFFFF_0000, 1'b0);
    check("R5 clk1 and-not", clk_stop1_o, 32'h0000_FFFF);
  endtask

  task automatic t_strap;
    wr_chk("R6 strap set", 16'h0500, 32'h0000_0100, 1'b0);
    check("R6 strap0 or", strap0_o, 32'h0000_01C0);
    wr_chk("R6 protect", 16'h0508, 32'h0000_0001, 1'b0);
    wr_chk("R6 frozen write no err", 16'h0500, 32'h0000_0002, 1'b0);
    check("R6 strap0 frozen", strap0_o, 32'h0000_01C0);
    wr_chk("R6 clear under protect", 16'h0504, 32'h0000_0040, 1'b0);
    check("R6 strap0 cleared", strap0_o, 32'h0000_0180);
    wr_chk("R6 strap1 set", 16'h0510, 32'h0000_0004, 1'b0);
    check("R6 strap1 or", strap1_o, 32'h0000_0005);
  endtask

  task automatic t_pll;
    rd_chk("R7 pll ext lock", 16'h0204, 32'h8000_0000, 1'b0);
    wr_chk("R7 pll ext write", 16'h0224, 32'h0000_1234, 1'b0);
    rd_chk("R7 pll ext forced", 16'h0224, 32'h8000_1234, 1'b0);
    rd_chk("R7 pll ext2", 16'h0244, 32'h8000_0000, 1'b0);
  endtask

  task automatic t_rand;
    for (int k = 0; k < 3; k++) begin
      rd_chk("R8 random read", 16'h0540, rng_model, 1'b0);
      rng_model = rng_step(rng_model);
    end
    wr_chk("R8 random write rejected", 16'h0540, 32'h0, 1'b1);
    rd_chk("R8 random continues", 16'h0540, rng_model, 1'b0);
    rng_model = rng_step(rng_model);
  endtask

  task automatic t_rev;
    rd_chk("R9 rev a", 16'h0004, 32'h0503_0303, 1'b0);
    wr_chk("R9 rev write err", 16'h0014, 32'hFFFF_FFFF, 1'b1);
    rd_chk("R9 rev b held", 16'h0014, 32'h0503_0303, 1'b0);
  endtask

  task automatic t_range;
    rd_chk("R10 beyond count", 16'h0580, 32'h0, 1'b1);
    wr_chk("R10 write beyond", 16'hFFFC, 32'h1, 1'b1);
    wr_chk("R12 plain write", 16'h0300, 32'hDEAD_BEEF, 1'b0);
    rd_chk("R12 plain read", 16'h0300, 32'hDEAD_BEEF, 1'b0);
    wr_chk("R1 unaligned write", 16'h0302, 32'h0, 1'b1);
    rd_chk("R1 unaligned read", 16'h0301, 32'h0, 1'b1);
    rd_chk("R1 word unchanged", 16'h0300, 32'hDEAD_BEEF, 1'b0);
  endtask

  task automatic t_relock;
    wr_chk("R2 relock", 16'h0000, 32'h0, 1'b0);
    check("R2 locked again", {31'h0, unlocked_o}, 32'h0);
    wr_chk("R3 relocked set", 16'h0080, 32'h1000_0000, 1'b1);
    check("R3 clk0 held", clk_stop0_o, 32'hEFF4_3E8B);
  endtask

  initial begin
    #5_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_key();
    t_setclr();
    t_strap();
    t_pll();
    t_rand();
    t_rev();
    t_range();
    t_relock();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule